// File: doc/BRIEF.md
# Receive Scatter-Gather Descriptor Writer

This block is the receive half of a scatter-gather DMA engine. It takes a packet that arrives one byte at a time on a stream port and writes it into memory buffers described by a chain of descriptors. Each descriptor gets as many bytes as its length field allows. The block then writes back a status word with frame markers. Application words that arrive on a separate control stream are kept and stored into the descriptor that ends the packet.

The block does not hold the control and status registers itself. It reads `run`, `idle_in`, the current descriptor pointer and the tail pointer from the register block. It asks that block to move the current pointer (`desc_adv` with `desc_next`), to set halted (`halt_set`) and to set idle (`idle_set`). It also gives a one-cycle completion event for each packet (`done_pulse`).

Memory is reached through a request/acknowledge port that uses byte addresses. The port does 32-bit reads and writes (`mem_be` = 4'b1111) and single-byte writes (`mem_be` = 4'b0001, byte on `mem_wdata[7:0]`). A descriptor at address D is laid out as follows: D+0 holds the next pointer, D+4 the buffer address, D+8 the control word (length in bits [22:0]), D+12 the status word, and D+16..D+32 the five application words.

The state machine has these states:
- ST_IDLE waits for data while run is set and idle is clear.
- ST_RD_NXT, ST_RD_BUF, ST_RD_CTL and ST_RD_STS fetch the descriptor.
- ST_DATA accepts a byte.
- ST_WR_BYTE stores the byte.
- ST_WB_APP stores the application words.
- ST_WB_STS writes the status.
- ST_ADV advances the chain.
- ST_HALTED holds until run falls.

Its transitions are:
- ST_IDLE to ST_RD_NXT on go.
- Each fetch state to the next one on acknowledge.
- ST_RD_STS to ST_HALTED if the descriptor is already complete, to ST_WB_STS if its length is zero, and to ST_DATA otherwise.
- ST_DATA to ST_WR_BYTE on an accepted byte.
- ST_WR_BYTE to ST_WB_APP on the packet's last byte, to ST_WB_STS when the buffer is full, and back to ST_DATA otherwise.
- ST_WB_APP to ST_WB_STS after the fifth word.
- ST_WB_STS to ST_ADV.
- ST_ADV to ST_IDLE at the tail or at end of packet, and to ST_RD_NXT otherwise.
- ST_HALTED to ST_IDLE when run drops.

Top module: `rx_sg_writer`

## Requirements
- R1: `s_ready` is high only while `run` is 1 and `idle_in` is 0; no byte is taken otherwise.
- R2: Each descriptor receives min(control[22:0], bytes left in the packet) bytes at consecutive buffer addresses. Bits above 22 of the control word are ignored. The count of bytes written goes into status[22:0], and bytes past that count stay untouched.
- R3: Status bit 27 is set only in the first descriptor of a packet, even when the packet resumes after a stop at the tail.
- R4: Status bit 26 is set only in the descriptor that takes the final byte. That descriptor's five application words at D+16..D+32 receive the latched control words in arrival order.
- R5: `done_pulse` is high for exactly one cycle per completed packet.
- R6: Every status word written has bit 31 set.
- R7: A fetched descriptor whose status bit 31 is already 1 raises `halt_set`. No memory write follows, and no byte is taken until `run` goes low.
- R8: After the status write of the descriptor whose address equals `tail_desc`, `desc_adv` and `idle_set` pulse together and reception stops. Otherwise `desc_adv` pulses with `desc_next` set to the next pointer.
- R9: A control packet of exactly five 32-bit words (last word flagged by `c_last`) is latched and used for the next packet that ends; `c_ready` is always high.
- R10: A control packet of any other length pulses `ctrl_err` the cycle after its last word and leaves the latched words unchanged.
- R11: A memory request holds its address, direction and data stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run control from the register block |
| idle_in | input | 1 | Idle status from the register block |
| cur_desc | input | AW | Current descriptor address |
| tail_desc | input | AW | Tail descriptor address |
| halt_set | output | 1 | Request to set halted |
| idle_set | output | 1 | Request to set idle |
| desc_adv | output | 1 | Load `desc_next` into the current pointer |
| desc_next | output | AW | Next descriptor address |
| done_pulse | output | 1 | Packet completion event |
| s_valid | input | 1 | Data byte valid |
| s_data | input | 8 | Data byte |
| s_last | input | 1 | Final byte of packet |
| s_ready | output | 1 | Data byte accepted |
| c_valid | input | 1 | Control word valid |
| c_data | input | 32 | Control word |
| c_last | input | 1 | Final control word |
| c_ready | output | 1 | Control word accepted (always 1) |
| ctrl_err | output | 1 | Bad control packet length |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | 4'b1111 word, 4'b0001 single byte |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench builds the block with an 11-bit address (AW = 11), the default 23-bit length field and five application words. This lets a 2 KiB byte array stand in for memory and hold twelve descriptors and their buffers. With this configuration, a sweep over every packet length from 1 to 12 against every descriptor length from 1 to 4 covers these cases:
- single-descriptor packets;
- exact fills;
- short final descriptors;
- chains of up to twelve descriptors.

Directed cases on the same configuration cover a stop at the tail in the middle of a packet, a pre-completed descriptor, and control packets that are too short or too long.

// File: rtl/rx_sg_pkg.sv
package rx_sg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_NXT,
        ST_RD_BUF,
        ST_RD_CTL,
        ST_RD_STS,
        ST_DATA,
        ST_WR_BYTE,
        ST_WB_APP,
        ST_WB_STS,
        ST_ADV,
        ST_HALTED
    } sg_state_e;

    // status word bit positions
    localparam int STAT_DONE_BIT = 31;
    localparam int STAT_SOF_BIT  = 27;
    localparam int STAT_EOF_BIT  = 26;

    // descriptor field byte offsets
    localparam int OFS_NEXT = 0;
    localparam int OFS_BUF  = 4;
    localparam int OFS_CTRL = 8;
    localparam int OFS_STAT = 12;
    localparam int OFS_APP  = 16;

endpackage

// File: rtl/rx_app_capture.sv
module rx_app_capture #(
    parameter int NW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_valid,
    input  logic [31:0]       c_data,
    input  logic              c_last,
    output logic [NW*32-1:0]  app_words,
    output logic              ctrl_err
);
    localparam int CW = $clog2(NW + 1);

    logic [CW-1:0] word_cnt;
    logic          len_ok;

    assign len_ok = (word_cnt == CW'(NW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_cnt <= '0;
            ctrl_err <= 1'b0;
        end else begin
            ctrl_err <= c_valid && c_last && !len_ok;
            if (c_valid) begin
                if (c_last)
                    word_cnt <= '0;
                else if (word_cnt != CW'(NW))
                    word_cnt <= word_cnt + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [31:0] shadow;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow                <= '0;
                app_words[g*32 +: 32] <= '0;
            end else if (c_valid) begin
                if (word_cnt == CW'(g))
                    shadow <= c_data;
                if (c_last && len_ok)
                    app_words[g*32 +: 32] <= (g == NW - 1) ? c_data : shadow;
            end
        end
    end

endmodule

// File: rtl/rx_sg_fsm.sv
module rx_sg_fsm
    import rx_sg_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 23,
    parameter int NW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              idle_in,
    input  logic [AW-1:0]     cur_desc,
    input  logic [AW-1:0]     tail_desc,
    output logic              halt_set,
    output logic              idle_set,
    output logic              desc_adv,
    output logic [AW-1:0]     desc_next,
    output logic              done_pulse,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic [NW*32-1:0]  app_words,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int IW = $clog2(NW + 1);

    sg_state_e     state, state_nx;
    logic [AW-1:0] dsc_addr, nxt_addr, buf_addr;
    logic [LW-1:0] len_cap, cnt, cnt_inc;
    logic [7:0]    byte_q;
    logic          last_q, sof_pend, eof_hit, gate, take;
    logic [IW-1:0] app_idx;
    logic [31:0]   stat_word;

    assign gate    = run && !idle_in;
    assign take    = (state == ST_DATA) && gate && s_valid;
    assign cnt_inc = cnt + 1'b1;

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_DONE_BIT] = 1'b1;
        stat_word[STAT_SOF_BIT]  = sof_pend;
        stat_word[STAT_EOF_BIT]  = eof_hit;
        stat_word[LW-1:0]        = cnt;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (gate && s_valid) state_nx = ST_RD_NXT;
            ST_RD_NXT:  if (mem_ack) state_nx = ST_RD_BUF;
            ST_RD_BUF:  if (mem_ack) state_nx = ST_RD_CTL;
            ST_RD_CTL:  if (mem_ack) state_nx = ST_RD_STS;
            ST_RD_STS:  if (mem_ack) begin
                            if (mem_rdata[STAT_DONE_BIT]) state_nx = ST_HALTED;
                            else if (len_cap == '0)       state_nx = ST_WB_STS;
                            else                          state_nx = ST_DATA;
                        end
            ST_DATA:    if (take) state_nx = ST_WR_BYTE;
            ST_WR_BYTE: if (mem_ack) begin
                            if (last_q)                state_nx = ST_WB_APP;
                            else if (cnt_inc == len_cap) state_nx = ST_WB_STS;
                            else                       state_nx = ST_DATA;
                        end
            ST_WB_APP:  if (mem_ack && app_idx == IW'(NW - 1)) state_nx = ST_WB_STS;
            ST_WB_STS:  if (mem_ack) state_nx = ST_ADV;
            ST_ADV:     if (dsc_addr == tail_desc || eof_hit) state_nx = ST_IDLE;
                        else                                  state_nx = ST_RD_NXT;
            ST_HALTED:  if (!run) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsc_addr <= '0;
            nxt_addr <= '0;
            buf_addr <= '0;
            len_cap  <= '0;
            cnt      <= '0;
            byte_q   <= '0;
            last_q   <= 1'b0;
            sof_pend <= 1'b1;
            eof_hit  <= 1'b0;
            app_idx  <= '0;
        end else begin
            if (state == ST_IDLE && state_nx == ST_RD_NXT) dsc_addr <= cur_desc;
            if (state == ST_ADV && state_nx == ST_RD_NXT)  dsc_addr <= nxt_addr;
            if (mem_ack) begin
                unique case (state)
                    ST_RD_NXT:  nxt_addr <= mem_rdata[AW-1:0];
                    ST_RD_BUF:  buf_addr <= mem_rdata[AW-1:0];
                    ST_RD_CTL:  len_cap  <= mem_rdata[LW-1:0];
                    ST_RD_STS:  begin cnt <= '0; eof_hit <= 1'b0; end
                    ST_WR_BYTE: begin
                                    cnt     <= cnt_inc;
                                    eof_hit <= last_q;
                                    app_idx <= '0;
                                end
                    ST_WB_APP:  app_idx  <= app_idx + 1'b1;
                    ST_WB_STS:  sof_pend <= eof_hit;
                    default:    ;
                endcase
            end
            if (take) begin
                byte_q <= s_data;
                last_q <= s_last;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = dsc_addr;
        mem_be     = 4'b1111;
        mem_wdata  = '0;
        s_ready    = 1'b0;
        desc_adv   = 1'b0;
        idle_set   = 1'b0;
        done_pulse = 1'b0;
        halt_set   = (state == ST_RD_STS) && mem_ack && mem_rdata[STAT_DONE_BIT];
        desc_next  = nxt_addr;
        unique case (state)
            ST_RD_NXT:  begin mem_req = 1'b1; mem_addr = dsc_addr + AW'(OFS_NEXT); end
            ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = dsc_addr + AW'(OFS_BUF);  end
            ST_RD_CTL:  begin mem_req = 1'b1; mem_addr = dsc_addr + AW'(OFS_CTRL); end
            ST_RD_STS:  begin mem_req = 1'b1; mem_addr = dsc_addr + AW'(OFS_STAT); end
            ST_DATA:    s_ready = gate;
            ST_WR_BYTE: begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_be    = 4'b0001;
                            mem_addr  = buf_addr + AW'(cnt);
                            mem_wdata = {24'd0, byte_q};
                        end
            ST_WB_APP:  begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = dsc_addr + AW'(OFS_APP) + AW'({app_idx, 2'b00});
                            mem_wdata = app_words[int'(app_idx)*32 +: 32];
                        end
            ST_WB_STS:  begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = dsc_addr + AW'(OFS_STAT);
                            mem_wdata = stat_word;
                        end
            ST_ADV:     begin
                            desc_adv   = 1'b1;
                            idle_set   = (dsc_addr == tail_desc);
                            done_pulse = eof_hit;
                        end
            default:    ;
        endcase
    end

endmodule

// File: rtl/rx_sg_writer.sv
module rx_sg_writer #(
    parameter int AW = 16,
    parameter int LW = 23,
    parameter int NW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          idle_in,
    input  logic [AW-1:0] cur_desc,
    input  logic [AW-1:0] tail_desc,
    output logic          halt_set,
    output logic          idle_set,
    output logic          desc_adv,
    output logic [AW-1:0] desc_next,
    output logic          done_pulse,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    output logic          s_ready,
    input  logic          c_valid,
    input  logic [31:0]   c_data,
    input  logic          c_last,
    output logic          c_ready,
    output logic          ctrl_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata
);
    logic [NW*32-1:0] app_words;

    assign c_ready = 1'b1;

    rx_app_capture #(.NW(NW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .c_valid   (c_valid),
        .c_data    (c_data),
        .c_last    (c_last),
        .app_words (app_words),
        .ctrl_err  (ctrl_err)
    );

    rx_sg_fsm #(.AW(AW), .LW(LW), .NW(NW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .idle_in    (idle_in),
        .cur_desc   (cur_desc),
        .tail_desc  (tail_desc),
        .halt_set   (halt_set),
        .idle_set   (idle_set),
        .desc_adv   (desc_adv),
        .desc_next  (desc_next),
        .done_pulse (done_pulse),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_last     (s_last),
        .s_ready    (s_ready),
        .app_words  (app_words),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

endmodule

// File: rtl/rx_sg_writer_chk.sv
module rx_sg_writer_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          idle_in,
    input logic          s_ready,
    input logic          halt_set,
    input logic          idle_set,
    input logic          done_pulse,
    input logic          c_valid,
    input logic          c_last,
    input logic          ctrl_err,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack
);
    assert_ready_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (run && !idle_in));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_set |=> (!s_ready && !mem_req));

    assert_tail_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_set |=> (!s_ready && !mem_req));

    assert_err_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_err |-> $past(c_valid && c_last));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
endmodule

bind rx_sg_writer rx_sg_writer_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .idle_in    (idle_in),
    .s_ready    (s_ready),
    .halt_set   (halt_set),
    .idle_set   (idle_set),
    .done_pulse (done_pulse),
    .c_valid    (c_valid),
    .c_last     (c_last),
    .ctrl_err   (ctrl_err),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/test_rx_sg_writer.sv
module test_rx_sg_writer;
    localparam int AW = 11;
    localparam int NDESC = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic run = 1'b0, idle_r = 1'b0;
    logic [AW-1:0] cur = '0, tail = '0;
    logic halt_set, idle_set, desc_adv, done_pulse, s_ready, c_ready, ctrl_err;
    logic [AW-1:0] desc_next, mem_addr;
    logic s_valid = 1'b0, s_last = 1'b0, c_valid = 1'b0, c_last = 1'b0;
    logic [7:0] s_data = '0;
    logic [31:0] c_data = '0, mem_wdata, mem_rdata = '0;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [3:0] mem_be;
    logic [7:0] mem [0:2047];

    int vectors = 0, fails = 0, cyc = 0;
    int done_cnt = 0, idle_cnt = 0, halt_cnt = 0, err_cnt = 0, acc_cnt = 0;

    always #2 clk = ~clk;

    rx_sg_writer #(.AW(AW)) i_rx_sg_writer (
        .clk(clk), .rst_n(rst_n), .run(run), .idle_in(idle_r),
        .cur_desc(cur), .tail_desc(tail), .halt_set(halt_set), .idle_set(idle_set),
        .desc_adv(desc_adv), .desc_next(desc_next), .done_pulse(done_pulse),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .c_valid(c_valid), .c_data(c_data), .c_last(c_last), .c_ready(c_ready),
        .ctrl_err(ctrl_err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model: acknowledge one half-cycle after a request is seen
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                if (mem_be == 4'b1111)
                    for (int b = 0; b < 4; b++) mem[int'(mem_addr) + b] = mem_wdata[b*8 +: 8];
                else
                    mem[int'(mem_addr)] = mem_wdata[7:0];
            end else begin
                mem_rdata <= {mem[int'(mem_addr)+3], mem[int'(mem_addr)+2],
                              mem[int'(mem_addr)+1], mem[int'(mem_addr)]};
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // register block model and event counters
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (desc_adv) cur <= desc_next;
            if (idle_set) begin idle_r <= 1'b1; idle_cnt <= idle_cnt + 1; end
            if (done_pulse) done_cnt <= done_cnt + 1;
            if (halt_set) halt_cnt <= halt_cnt + 1;
            if (ctrl_err) err_cnt <= err_cnt + 1;
            if (s_valid && s_ready) acc_cnt <= acc_cnt + 1;
        end
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog (all requirements): actual %0d cycles, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic wr32(input int a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[a+b] = v[b*8 +: 8];
    endtask

    function automatic int dsc(input int k); return k * 64; endfunction
    function automatic int bufa(input int k); return 768 + k * 32; endfunction

    task automatic init_mem(input int l);
        for (int a = 0; a < 2048; a++) mem[a] = 8'h00;
        for (int k = 0; k < NDESC; k++) begin
            wr32(dsc(k), dsc(k + 1));
            wr32(dsc(k) + 4, bufa(k));
            wr32(dsc(k) + 8, 32'h0F80_0000 | l);   // junk above bit 22
        end
    endtask

    task automatic send_ctrl(input int nw, input logic [31:0] base);
        for (int i = 0; i < nw; i++) begin
            c_valid = 1'b1; c_data = base + i; c_last = (i == nw - 1);
            @(negedge clk);
        end
        c_valid = 1'b0; c_last = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic lst);
        s_valid = 1'b1; s_data = b; s_last = lst;
        forever begin
            if (s_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic wait_idle(input int target);
        for (int t = 0; t < 2000 && idle_cnt < target; t++) @(negedge clk);
        chk("R8 idle_set reached", idle_cnt, target);
    endtask

    // check one descriptor: bytes, markers, guard byte
    task automatic chk_desc(input int k, input int bytes, input logic sof, input logic eof,
                            input int pat_base);
        logic [31:0] st;
        logic ok;
        st = rd32(dsc(k) + 12);
        chk("R6 status bit31", {31'd0, st[31]}, 32'd1);
        chk("R3 sof bit27", {31'd0, st[27]}, {31'd0, sof});
        chk("R4 eof bit26", {31'd0, st[26]}, {31'd0, eof});
        chk("R2 length field", {9'd0, st[22:0]}, bytes);
        ok = 1'b1;
        for (int i = 0; i < bytes; i++)
            if (mem[bufa(k) + i] !== 8'((pat_base + i) * 7 + 3)) ok = 1'b0;
        chk("R2 buffer bytes", {31'd0, ok}, 32'd1);
        chk("R2 guard byte untouched", {24'd0, mem[bufa(k) + bytes]}, 32'd0);
    endtask

    task automatic chk_app(input int k, input logic [31:0] base);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 5; i++) if (rd32(dsc(k) + 16 + 4*i) !== base + i) ok = 1'b0;
        chk("R4 R9 application words", {31'd0, ok}, 32'd1);
    endtask

    task automatic run_case(input int p, input int l);
        int n, d0, bytes;
        logic [31:0] base;
        n = (p + l - 1) / l;
        base = 32'hA000_0000 | (p << 8) | (l << 4);
        init_mem(l);
        cur = '0; tail = AW'(dsc(n - 1)); idle_r = 1'b0; run = 1'b1;
        d0 = done_cnt;
        send_ctrl(5, base);
        for (int i = 0; i < p; i++) send_byte(8'(i * 7 + 3), i == p - 1);
        wait_idle(idle_cnt + 1);
        repeat (3) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            bytes = (p - k*l > l) ? l : p - k*l;
            chk_desc(k, bytes, k == 0, k == n - 1, k * l);
        end
        chk_app(n - 1, base);
        if (n > 1) chk("R4 no app on earlier descriptor", rd32(dsc(0) + 16), 32'd0);
        if (n < NDESC) chk("R8 descriptor past tail untouched", rd32(dsc(n) + 12), 32'd0);
        chk("R5 one done pulse", done_cnt - d0, 32'd1);
        chk("R8 current pointer advanced", {21'd0, cur}, dsc(n));
    endtask

    initial begin
        int a0, h0, e0, i0, d0;
        logic [31:0] good;
        repeat (3) @(negedge clk);
        chk("R1 reset ready low", {31'd0, s_ready}, 32'd0);
        chk("R11 reset no request", {31'd0, mem_req}, 32'd0);
        chk("R9 control always ready", {31'd0, c_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: run low, then idle high
        init_mem(4);
        a0 = acc_cnt;
        s_valid = 1'b1; s_data = 8'h55;
        repeat (12) @(negedge clk);
        chk("R1 no accept with run low", acc_cnt - a0, 32'd0);
        run = 1'b1; idle_r = 1'b1;
        repeat (12) @(negedge clk);
        chk("R1 no accept while idle", acc_cnt - a0, 32'd0);
        chk("R1 ready low while idle", {31'd0, s_ready}, 32'd0);
        s_valid = 1'b0; idle_r = 1'b0;
        @(negedge clk);

        // sweep packet length and descriptor length
        for (int p = 1; p <= 12; p++)
            for (int l = 1; l <= 4; l++)
                run_case(p, l);

        // R7: descriptor already complete
        init_mem(2);
        wr32(dsc(0) + 12, 32'h8000_0000);
        cur = '0; tail = AW'(dsc(3)); idle_r = 1'b0; run = 1'b1;
        a0 = acc_cnt; h0 = halt_cnt;
        s_valid = 1'b1; s_data = 8'h77; s_last = 1'b1;
        repeat (30) @(negedge clk);
        chk("R7 halt_set raised once", halt_cnt - h0, 32'd1);
        chk("R7 no byte taken", acc_cnt - a0, 32'd0);
        chk("R7 buffer untouched", {24'd0, mem[bufa(0)]}, 32'd0);
        chk("R7 status unchanged", rd32(dsc(0) + 12), 32'h8000_0000);
        run = 1'b0;
        repeat (3) @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        @(negedge clk);
        run = 1'b1;

        // R8 + R3: tail reached mid-packet, then resumed
        init_mem(2);
        cur = '0; tail = AW'(dsc(0)); idle_r = 1'b0;
        i0 = idle_cnt; d0 = done_cnt;
        good = 32'hC0DE_0100;
        send_ctrl(5, good);
        fork
            for (int i = 0; i < 6; i++) send_byte(8'(i * 7 + 3), i == 5);
            begin
                wait_idle(i0 + 1);
                repeat (6) @(negedge clk);
                chk("R8 reception stopped at tail", acc_cnt - a0, 32'd2);
                chk("R5 no done before packet end", done_cnt - d0, 32'd0);
                tail = AW'(dsc(2)); idle_r = 1'b0;
            end
        join
        wait_idle(i0 + 2);
        repeat (3) @(negedge clk);
        chk_desc(0, 2, 1'b1, 1'b0, 0);
        chk_desc(1, 2, 1'b0, 1'b0, 2);
        chk_desc(2, 2, 1'b0, 1'b1, 4);
        chk_app(2, good);
        chk("R5 resumed packet single done", done_cnt - d0, 32'd1);

        // R10: bad control lengths keep previous words
        e0 = err_cnt;
        send_ctrl(3, 32'hBAD0_0000);
        chk("R10 short control flagged", err_cnt - e0, 32'd1);
        send_ctrl(6, 32'hBAD1_0000);
        chk("R10 long control flagged", err_cnt - e0, 32'd2);
        init_mem(4);
        cur = '0; tail = AW'(dsc(0)); idle_r = 1'b0;
        i0 = idle_cnt;
        send_byte(8'd3, 1'b0);
        send_byte(8'd10, 1'b1);
        wait_idle(i0 + 1);
        repeat (3) @(negedge clk);
        chk_desc(0, 2, 1'b1, 1'b1, 0);
        chk_app(0, good);

        // R9: a good packet after errors replaces the words
        send_ctrl(5, 32'h1234_0000);
        chk("R10 good control not flagged", err_cnt - e0, 32'd2);
        init_mem(4);
        cur = '0; tail = AW'(dsc(0)); idle_r = 1'b0;
        i0 = idle_cnt;
        send_byte(8'd3, 1'b1);
        wait_idle(i0 + 1);
        repeat (3) @(negedge clk);
        chk_app(0, 32'h1234_0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule